// File: doc/BRIEF.md
# Dual-Channel Serial ADC Reader

This block is the host side of a link to a two-channel, simultaneous-sampling converter. A start pulse makes it pull chip select low, which freezes both analog inputs and starts conversion. It then generates a serial clock from the system clock and collects the returned bits. Each returned stream opens with two zero bits, then gives a 12-bit result with the most significant bit first, and may end with padding zeros.

Three frame formats are available. The short and padded formats read channel A from one data line and channel B from the other at the same time. The long format keeps chip select low for a second half-frame and takes both results from line A only. The serial clock half-period is set per frame by a divider value. When the frame ends, chip select returns high and a one-cycle done strobe marks two fresh 12-bit results.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, cs_n and sclk are 1, done is 0, and res_a and res_b are 0.
- R2: When the block is idle and start is 1 at a clock edge, cs_n goes low after that edge. sclk then stays high for half_div+1 system clocks before its first falling edge, and sclk never falls in the cycle where cs_n falls.
- R3: While cs_n is low, each sclk level lasts half_div+1 system clocks. While cs_n is high, sclk is 1.
- R4: mode selects how many sclk falling edges a frame has: 2'b00 gives 14, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32.
- R5: The k-th sample (k counted from 1) is the value a data line held just before the k-th sclk falling edge. Samples 3 to 14 are a result, most significant bit first.
- R6: In modes 2'b00 and 2'b01, res_a is taken from samples 3 to 14 of sdata_a and res_b from samples 3 to 14 of sdata_b.
- R7: In modes 2'b10 and 2'b11, res_a is samples 3 to 14 of sdata_a and res_b is samples 17 to 28 of sdata_a. sdata_b has no effect.
- R8: One half-period after the last falling edge, sclk and cs_n rise together and done is 1 for exactly that one cycle. res_a and res_b take their new values in that cycle and change at no other time.
- R9: mode and half_div are latched at start. A start pulse or a change of mode or half_div while cs_n is low has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a frame |
| mode | input | 2 | Frame format select |
| half_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sdata_a | input | 1 | Serial data line A |
| sdata_b | input | 1 | Serial data line B |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| done | output | 1 | One-cycle strobe when results are updated |
| res_a | output | 12 | Channel A result |
| res_b | output | 12 | Channel B result |

## Verification
The bench targets the sample-to-bit alignment. A reader that is off by one falling edge returns results shifted by one bit with a stray zero or a bit of the next field. Long-format frames run with line B driven to all ones: a design that still reads channel B from line B returns 0xFFF, and one that uses the wrong window returns a shifted value. Mid-frame start pulses and mode and divider changes catch a controller that restarts or re-times a running frame. Divider values 0 to 3 and a measured lead time between chip select falling and the first clock edge expose an off-by-one in the half-period count and a first edge that lands on the chip-select edge.

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DIV_W = 8,
  parameter int RES_W = 12,
  parameter int LEAD  = 2,
  parameter int TRAIL = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sdata_a,
  input  logic             sdata_b,
  output logic             cs_n,
  output logic             sclk,
  output logic             done,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b
);
  localparam int F_SHORT = LEAD + RES_W;
  localparam int F_MID   = F_SHORT + TRAIL;
  localparam int F_LONG  = 2 * F_MID;
  localparam int CNT_W   = $clog2(F_LONG + 1);

  logic [1:0]       md;
  logic [DIV_W-1:0] hd, divcnt;
  logic [CNT_W-1:0] fcnt, nxt, flen;
  logic [RES_W-1:0] ra, rb;
  logic             tick, win_a, win_b2, take_b, bit_b;

  assign flen   = md[1] ? CNT_W'(F_LONG) : (md[0] ? CNT_W'(F_MID) : CNT_W'(F_SHORT));
  assign tick   = (divcnt == hd);
  assign nxt    = fcnt + 1'b1;
  assign win_a  = (nxt >= CNT_W'(LEAD + 1)) && (nxt <= CNT_W'(LEAD + RES_W));
  assign win_b2 = (nxt >= CNT_W'(F_MID + 1)) && (nxt <= CNT_W'(F_MID + RES_W));
  assign take_b = md[1] ? win_b2 : win_a;
  assign bit_b  = md[1] ? sdata_a : sdata_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      sclk   <= 1'b1;
      done   <= 1'b0;
      md     <= '0;
      hd     <= '0;
      divcnt <= '0;
      fcnt   <= '0;
      ra     <= '0;
      rb     <= '0;
      res_a  <= '0;
      res_b  <= '0;
    end else begin
      done <= 1'b0;
      if (cs_n) begin
        if (start) begin
          cs_n   <= 1'b0;
          md     <= mode;
          hd     <= half_div;
          divcnt <= '0;
          fcnt   <= '0;
        end
      end else if (!tick) begin
        divcnt <= divcnt + 1'b1;
      end else begin
        divcnt <= '0;
        if (sclk) begin
          sclk <= 1'b0;
          fcnt <= nxt;
          if (win_a)  ra <= {ra[RES_W-2:0], sdata_a};
          if (take_b) rb <= {rb[RES_W-2:0], bit_b};
        end else begin
          sclk <= 1'b1;
          if (fcnt == flen) begin
            cs_n  <= 1'b1;
            done  <= 1'b1;
            res_a <= ra;
            res_b <= rb;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             done,
  input logic [RES_W-1:0] res_a,
  input logic [RES_W-1:0] res_b
);
  AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk); // R3
  AST_NO_EDGE_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> sclk); // R2
  AST_FALL_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (!cs_n && $past(!cs_n))); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(cs_n) && $rose(sclk))); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_a) && $stable(res_b))); // R8
endmodule

bind dual_adc_reader dual_adc_reader_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .done(done), .res_a(res_a), .res_b(res_b)
);

// File: tb/dual_adc_reader_bench.sv
module dual_adc_reader_bench;
  localparam int DW = 8;
  localparam int RW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [DW-1:0] half_div = '0;
  logic sdata_a, sdata_b, cs_n, sclk, done;
  logic [RW-1:0] res_a, res_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dual_adc_reader u_dual_adc_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .half_div(half_div),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .cs_n(cs_n), .sclk(sclk), .done(done),
    .res_a(res_a), .res_b(res_b)
  );

  // converter model: bit index = falling edges since this frame began
  logic [31:0] strm_a = '0, strm_b = '0;
  int tot_fall = 0, base = 0;
  always @(negedge sclk) tot_fall = tot_fall + 1;
  assign sdata_a = (cs_n || (tot_fall - base) > 31) ? 1'b1 : strm_a[31 - (tot_fall - base)];
  assign sdata_b = (cs_n || (tot_fall - base) > 31) ? 1'b1 : strm_b[31 - (tot_fall - base)];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // behavioural reference, evaluated every clock
  bit m_busy = 0, m_sclk = 1, m_done = 0, m_long = 0;
  int m_cnt = 0, m_fall = 0, m_len = 14, m_hd = 0;
  logic [RW-1:0] m_ra = '0, m_rb = '0;
  bit qa[$], qb[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_sclk = 1; m_done = 0; m_ra = '0; m_rb = '0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_cnt = 0; m_fall = 0; qa.delete(); qb.delete();
          m_hd = int'(half_div); m_long = mode[1];
          m_len = (mode == 2'b00) ? 14 : (mode == 2'b01) ? 16 : 32;
        end
      end else begin
        m_cnt++;
        if (m_cnt > m_hd) begin
          m_cnt = 0;
          if (m_sclk) begin
            m_sclk = 0; m_fall++;
            qa.push_back(sdata_a); qb.push_back(sdata_b);
          end else begin
            m_sclk = 1;
            if (m_fall == m_len) begin
              m_busy = 0; m_done = 1;
              for (int i = 0; i < 12; i++) begin
                m_ra[11-i] = qa[2+i];
                m_rb[11-i] = m_long ? qa[16+i] : qb[2+i];
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cs_n == !m_busy, "R2 cs_n vs model", cs_n, !m_busy);
    chk(sclk == m_sclk, "R3 R4 sclk vs model", sclk, m_sclk);
    chk(done == m_done, "R8 done vs model", done, m_done);
    chk(res_a == m_ra, "R5 R6 res_a vs model", res_a, m_ra);
    chk(res_b == m_rb, "R5 R7 res_b vs model", res_b, m_rb);
  end

  task automatic run_frame(input logic [1:0] md, input int hd, input logic [11:0] va,
                           input logic [11:0] vb, input bit junk_b, input bit poke);
    int lead = 0;
    int exp_len = (md == 2'b00) ? 14 : (md == 2'b01) ? 16 : 32;
    bit seen = 0;
    strm_a = {2'b00, va, 2'b00, vb, 4'b0000};
    strm_b = junk_b ? 32'hFFFF_FFFF : {2'b00, vb, 2'b00, va, 4'b0000};
    base = tot_fall;
    @(negedge clk);
    mode = md; half_div = DW'(hd); start = 1'b1;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      if (t == 0) start = 1'b0;
      if (!cs_n && sclk && tot_fall == base) lead++;
      if (done) begin seen = 1; break; end
      // R9: disturb the running frame
      if (poke && t == 20) begin start = 1'b1; mode = ~md; half_div = DW'(hd + 2); end
      if (poke && t == 22) start = 1'b0;
    end
    start = 1'b0;
    chk(seen, "R8 done reached", seen, 1);
    chk(lead == hd + 1, "R2 lead time", lead, hd + 1);
    chk(tot_fall - base == exp_len, "R4 falling edges", tot_fall - base, exp_len);
    chk(res_a == va, md[1] ? "R7 res_a" : "R6 res_a", res_a, va);
    chk(res_b == vb, md[1] ? "R7 res_b line B ignored" : "R6 res_b", res_b, vb);
    chk(cs_n && sclk, "R8 cs_n and sclk high at done", {cs_n, sclk}, 3);
    @(negedge clk);
    chk(!done && res_a == va && res_b == vb, "R8 done single and results held", done, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && sclk && !done, "R1 idle lines", {cs_n, sclk, done}, 6);
    chk(res_a == 0 && res_b == 0, "R1 results cleared", res_a, 0);
    run_frame(2'b00, 0, 12'hABC, 12'h123, 0, 0);
    run_frame(2'b01, 1, 12'hFFF, 12'h001, 0, 0);
    run_frame(2'b10, 2, 12'h800, 12'h7FF, 1, 0);
    run_frame(2'b11, 0, 12'h5A5, 12'hA5A, 1, 0);
    run_frame(2'b00, 3, 12'h3C3, 12'hC3C, 0, 1);
    run_frame(2'b10, 1, 12'h001, 12'hFFE, 1, 1);
    run_frame(2'b01, 0, 12'h000, 12'hFFF, 0, 0);
    run_frame(2'b01, 2, 12'h96A, 12'h14D, 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule